// File: doc/BRIEF.md
# Accumulator Saturate and Negate Unit

This unit applies one single-operand accumulator operation to a 32-bit data word per accepted input. It negates the word, clamps it to a signed or unsigned byte or halfword range, or inverts every bit. When it negates, it also produces the overflow and advance-overflow status bits and the sticky copies of both. An opcode decoder upstream supplies a 3-bit operation select together with the operand and a valid strobe. The result register drives the write-back into the same data register.

One cycle after the input valid is high, the result and valid are presented from registers. The four status bits live in the unit. Only a negate changes them. Every other operation leaves all four as they were, so the sticky bits build up across a stream of instructions until reset clears them.

Top module: `acc_unit`

## Requirements
- R1: With operation code 0 (negate), the result is zero minus the operand, modulo 2^32.
- R2: A negate sets the overflow bit to 1 exactly when the operand is 0x80000000 and to 0 otherwise; the sticky overflow bit becomes its old value OR the new overflow bit.
- R3: A negate sets the advance-overflow bit to result bit 31 XOR result bit 30; the sticky advance-overflow bit becomes its old value OR the new advance-overflow bit.
- R4: Code 1 treats the operand as signed and clamps it to the range -128..127.
- R5: Code 3 treats the operand as signed and clamps it to the range -32768..32767.
- R6: Code 2 compares the operand as unsigned against 0xFF and returns 0xFF when it is larger, so any operand with bit 31 set yields 0xFF.
- R7: Code 4 compares the operand as unsigned against 0xFFFF and returns 0xFFFF when it is larger.
- R8: Code 5 returns the bitwise complement of the operand.
- R9: Codes 1 to 7 leave all four status bits unchanged.
- R10: Codes 6 and 7 return the operand unchanged.
- R11: out_valid is in_valid delayed by one clock. While in_valid is low, out_data and the status bits hold their values.
- R12: A synchronous active-high reset clears out_valid, out_data and all four status bits on the next clock edge, and it overrides a valid input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and operation select are valid |
| in_op | input | 3 | Operation select (0 neg, 1 sat s8, 2 sat u8, 3 sat s16, 4 sat u16, 5 not) |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Registered result is valid |
| out_data | output | 32 | Registered result |
| out_ovf | output | 1 | Overflow status bit |
| out_aovf | output | 1 | Advance-overflow status bit |
| out_sovf | output | 1 | Sticky overflow status bit |
| out_saovf | output | 1 | Sticky advance-overflow status bit |

## Verification
Two things can land on the status registers in the same cycle: a negate that raises a new flag, and the sticky bit that already holds an earlier one. The bench provokes this by running the most negative operand and operands near ±2^30 through negate, both back to back and between saturations. The bench's own running flag model must then agree with all four bits after every single operation. Reset and a valid negate are also driven in the same cycle, and the bench expects every register to come back cleared.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int OP_W   = 3;
    localparam int SAT_N  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NEG   = 3'd0,
        OP_SATB  = 3'd1,
        OP_SATBU = 3'd2,
        OP_SATH  = 3'd3,
        OP_SATHU = 3'd4,
        OP_NOT   = 3'd5
    } acc_op_e;

    typedef struct packed {
        logic ovf;
        logic aovf;
    } acc_flags_t;

    typedef struct packed {
        logic ovf;
        logic aovf;
        logic sovf;
        logic saovf;
    } acc_status_t;

    // Saturator i serves opcode i+1: even i signed, i < 2 byte width
    function automatic int sat_width(input int idx);
        return (idx < 2) ? BYTE_W : HALF_W;
    endfunction

    function automatic bit sat_signed(input int idx);
        return (idx % 2) == 0;
    endfunction

endpackage

// File: rtl/acc_negate.sv
module acc_negate
    import acc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output acc_flags_t   flags
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        dout       = '0 - din;
        flags.ovf  = (din == MOST_NEG);
        // doubling the result and XOR-ing exposes the top two bits differing
        flags.aovf = dout[W-1] ^ dout[W-2];
    end
endmodule

// File: rtl/acc_saturate.sv
module acc_saturate
    import acc_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int SAT_W  = BYTE_W,
    parameter bit SIGNED = 1'b1
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (SIGNED) begin : g_signed
            localparam logic signed [W-1:0] HI = W'((64'sd1 <<< (SAT_W-1)) - 64'sd1);
            localparam logic signed [W-1:0] LO = W'(-(64'sd1 <<< (SAT_W-1)));
            logic signed [W-1:0] low_cl;
            always_comb begin
                low_cl = ($signed(din) < LO) ? LO : $signed(din);
                dout   = (low_cl > HI) ? HI : low_cl;
            end
        end else begin : g_unsigned
            localparam logic [W-1:0] HI = W'((64'd1 << SAT_W) - 64'd1);
            always_comb dout = (din > HI) ? HI : din;
        end
    endgenerate
endmodule

// File: rtl/acc_status.sv
module acc_status
    import acc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd,
    input  acc_flags_t  nflags,
    output acc_status_t st
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (upd) begin
            st.ovf   <= nflags.ovf;
            st.aovf  <= nflags.aovf;
            st.sovf  <= st.sovf  | nflags.ovf;
            st.saovf <= st.saovf | nflags.aovf;
        end
    end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ovf,
    output logic              out_aovf,
    output logic              out_sovf,
    output logic              out_saovf
);
    logic [DATA_W-1:0] neg_res;
    acc_flags_t        neg_flags;
    logic [DATA_W-1:0] sat_res [SAT_N];
    logic [DATA_W-1:0] nxt_data;
    logic              flag_upd;
    acc_status_t       st;

    acc_negate #(.W(DATA_W)) u_neg (
        .din   (in_data),
        .dout  (neg_res),
        .flags (neg_flags)
    );

    generate
        for (genvar i = 0; i < SAT_N; i++) begin : g_sat
            acc_saturate #(
                .W      (DATA_W),
                .SAT_W  (sat_width(i)),
                .SIGNED (sat_signed(i))
            ) u_sat (
                .din  (in_data),
                .dout (sat_res[i])
            );
        end
    endgenerate

    always_comb begin
        nxt_data = in_data;
        flag_upd = 1'b0;
        case (in_op)
            OP_NEG: begin
                nxt_data = neg_res;
                flag_upd = in_valid;
            end
            OP_SATB:  nxt_data = sat_res[0];
            OP_SATBU: nxt_data = sat_res[1];
            OP_SATH:  nxt_data = sat_res[2];
            OP_SATHU: nxt_data = sat_res[3];
            OP_NOT:   nxt_data = ~in_data;
            default:  nxt_data = in_data;
        endcase
    end

    acc_status u_status (
        .clk    (clk),
        .rst    (rst),
        .upd    (flag_upd),
        .nflags (neg_flags),
        .st     (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= nxt_data;
        end
    end

    assign out_ovf   = st.ovf;
    assign out_aovf  = st.aovf;
    assign out_sovf  = st.sovf;
    assign out_saovf = st.saovf;
endmodule

// File: rtl/acc_unit_chk.sv
module acc_unit_chk
    import acc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ovf,
    input logic              out_aovf,
    input logic              out_sovf,
    input logic              out_saovf
);
    logic is_neg;
    assign is_neg = in_valid && (in_op == OP_NEG);

    p_neg_result_r1: assert property (@(posedge clk) disable iff (rst)
        is_neg |=> out_data == DATA_W'(0 - $past(in_data)));

    p_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        is_neg |=> out_ovf == ($past(in_data) == 32'h8000_0000));

    p_sticky_ovf_r2: assert property (@(posedge clk) disable iff (rst)
        out_sovf |=> out_sovf);

    p_aovf_r3: assert property (@(posedge clk) disable iff (rst)
        is_neg |=> out_aovf == (out_data[31] ^ out_data[30]));

    p_sticky_aovf_r3: assert property (@(posedge clk) disable iff (rst)
        out_saovf |=> out_saovf);

    p_satb_range_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_SATB) |=>
        ($signed(out_data) >= -128 && $signed(out_data) <= 127));

    p_sath_range_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_SATH) |=>
        ($signed(out_data) >= -32768 && $signed(out_data) <= 32767));

    p_not_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == OP_NOT) |=> out_data == ~$past(in_data));

    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !is_neg |=> $stable({out_ovf, out_aovf, out_sovf, out_saovf}));

    p_valid_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    p_reset_r12: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0 && !out_sovf && !out_saovf));
endmodule

bind acc_unit acc_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ovf   (out_ovf),
    .out_aovf  (out_aovf),
    .out_sovf  (out_sovf),
    .out_saovf (out_saovf)
);

// File: tb/test_acc_unit.sv
`timescale 1ns/1ps
module test_acc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ovf, out_aovf, out_sovf, out_saovf;

    int checks = 0;
    int errors = 0;
    logic m_ovf = 0, m_aovf = 0, m_sovf = 0, m_saovf = 0;

    always #10 clk = ~clk;

    acc_unit i_acc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_ovf(out_ovf), .out_aovf(out_aovf),
        .out_sovf(out_sovf), .out_saovf(out_saovf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] x);
        longint s;
        s = longint'($signed(x));
        case (op)
            3'd0: return 32'(0 - x);
            3'd1: return (s < -128) ? 32'hFFFF_FF80 : (s > 127) ? 32'd127 : x;
            3'd2: return (x > 32'hFF) ? 32'hFF : x;
            3'd3: return (s < -32768) ? 32'hFFFF_8000 : (s > 32767) ? 32'd32767 : x;
            3'd4: return (x > 32'hFFFF) ? 32'hFFFF : x;
            3'd5: return ~x;
            default: return x;
        endcase
    endfunction

    function automatic string data_req(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R4";
            3'd2: return "R6";
            3'd3: return "R5";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Called at a falling edge; returns at the next falling edge with in_valid low
    task automatic xact(input logic [2:0] op, input logic [31:0] x);
        logic [31:0] exp;
        string fr;
        in_valid = 1'b1;
        in_op    = op;
        in_data  = x;
        exp = model(op, x);
        if (op == 3'd0) begin
            m_ovf   = (x == 32'h8000_0000);
            m_aovf  = exp[31] ^ exp[30];
            m_sovf  = m_sovf | m_ovf;
            m_saovf = m_saovf | m_aovf;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 valid", {31'd0, out_valid}, 32'd1);
        chk(data_req(op), out_data, exp);
        fr = (op == 3'd0) ? "R2/R3 flags" : "R9 flags";
        chk(fr, {28'd0, out_ovf, out_aovf, out_sovf, out_saovf},
            {28'd0, m_ovf, m_aovf, m_sovf, m_saovf});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (2) @(negedge clk);
        chk("R12 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R12 reset data", out_data, 32'd0);
        chk("R12 reset flags", {28'd0, out_ovf, out_aovf, out_sovf, out_saovf}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // saturation and pass-through sweeps leave clean flags alone (R9)
        for (int op = 1; op < 8; op++) begin
            for (int v = -300; v <= 300; v++) xact(3'(op), 32'(v));
            for (int v = 32'h7F00; v <= 32'h8100; v += 3) xact(3'(op), 32'(v));
            for (int v = -32'h8100; v <= -32'h7F00; v += 3) xact(3'(op), 32'(v));
            xact(3'(op), 32'h8000_0000);
            xact(3'(op), 32'h7FFF_FFFF);
            xact(3'(op), 32'hFFFF_FFFF);
            xact(3'(op), 32'h0001_0000);
        end

        // negate: small values, then around +-2^30, then most negative
        for (int v = -40; v <= 40; v++) xact(3'd0, 32'(v));
        for (int v = -3; v <= 3; v++) xact(3'd0, 32'h4000_0000 + 32'(v));
        xact(3'd2, 32'h8000_0001);           // R9: sticky aovf survives a saturate
        for (int v = -3; v <= 3; v++) xact(3'd0, 32'hC000_0000 + 32'(v));
        xact(3'd0, 32'h8000_0000);
        xact(3'd0, 32'h8000_0000);           // R2: back-to-back overflow
        xact(3'd0, 32'd5);                   // R2: overflow clears, sticky stays
        for (int op = 1; op < 8; op++) xact(3'(op), 32'h8000_0000);
        xact(3'd0, 32'h8000_0001);

        // R11: idle cycle holds data and flags
        held = out_data;
        @(negedge clk);
        chk("R11 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R11 idle data", out_data, held);
        chk("R11 idle flags", {28'd0, out_ovf, out_aovf, out_sovf, out_saovf},
            {28'd0, m_ovf, m_aovf, m_sovf, m_saovf});

        // R12: reset together with a valid overflowing negate
        rst = 1'b1;
        in_valid = 1'b1;
        in_op = 3'd0;
        in_data = 32'h8000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R12 reset beats valid", {31'd0, out_valid}, 32'd0);
        chk("R12 reset data", out_data, 32'd0);
        chk("R12 reset flags", {28'd0, out_ovf, out_aovf, out_sovf, out_saovf}, 32'd0);
        rst = 1'b0;
        m_ovf = 0; m_aovf = 0; m_sovf = 0; m_saovf = 0;
        @(negedge clk);
        xact(3'd0, 32'h0000_0001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule